// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block gathers interrupt events from hardware into a bank of cause bits and offers them to software through seven 32-bit registers on a simple read/write port with a word address. Every source owns one bit index, and that index means the same source in all seven registers. Software can read the raw causes, read the causes with masked sources hidden, raise causes itself, and change the mask by direct write or by set and clear strobes.

For each bit, a control register chooses how a pending cause is retired. In one mode software writes a 1 to clear it. In the other mode a read clears it. The same choice applies whether software reaches the bit through the raw cause register or through the masked view. A single registered interrupt output is high while any unmasked cause is pending.

Top module: `irq_cause_bank`

## Requirements
- R1: After synchronous reset, every cause bit is 0, every mask bit is 1, the control register is 0, `irq_out` is 0 and `rd_data` is 0.
- R2: The word offsets are: 0 control (read/write), 1 cause, 2 masked cause, 3 cause-set, 4 mask value, 5 mask-set, 6 mask-clear. Offset 7 reads as 0 and ignores writes. `rd_data` is loaded on the clock edge that samples `rd_en`, and holds its value otherwise. Bits at N_SRC and above read as 0.
- R3: A high `hw_evt[i]` sets cause bit i on that clock edge. If a clear by write or by read hits the same bit in the same cycle, the event wins and the bit ends set.
- R4: Writing offset 3 sets every cause bit whose data bit is 1. Other cause bits are unchanged.
- R5: With control bit i at 0 (write-1-to-clear), writing a 1 to bit i of offset 1 clears cause bit i. Writing a 1 to bit i of offset 2 clears it only while mask bit i is 0. Reads never clear such a bit.
- R6: With control bit i at 1 (clear-on-read), a read of offset 1 returns cause bit i and clears it. A read of offset 2 clears it only while mask bit i is 0. Writes to offsets 1 and 2 never clear such a bit.
- R7: A read of offset 2 returns the cause bits ANDed with the inverse of the mask bits.
- R8: A write to offset 4 loads the mask directly. A write to offset 5 sets the mask bits where the data is 1. A write to offset 6 clears the mask bits where the data is 1.
- R9: `irq_out` is a register that equals the OR of (cause AND NOT mask). It takes the new value on the same edge that updates the cause or mask bits.
- R10: Reads of offsets 3, 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | N_SRC | Hardware event per source, one-cycle or level |
| reg_addr | input | 3 | Register word offset |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for the current cycle |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A write or a hardware event takes effect on the edge that samples it. Its effect is visible to a read strobed in the next cycle, and `irq_out` shows the new value right after that same edge. Read data arrives one edge after the read strobe. A clear-on-read removes bits on that same edge, so the returned word shows the value before the clear. The bench drives every strobe for exactly one cycle at a falling edge. It compares `rd_data` and `irq_out` at the next falling edge against a model that it updates from the requirements at the same point.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL   = 3'd0,
        OFS_CAUSE  = 3'd1,
        OFS_MASKED = 3'd2,
        OFS_SET    = 3'd3,
        OFS_MASK   = 3'd4,
        OFS_MSET   = 3'd5,
        OFS_MCLR   = 3'd6,
        OFS_NONE   = 3'd7
    } reg_ofs_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_cause;
        logic wr_masked;
        logic wr_set;
        logic wr_mask;
        logic wr_mset;
        logic wr_mclr;
        logic rd_cause;
        logic rd_masked;
    } strobe_t;

    function automatic strobe_t decode_strobes(logic wr, logic rd, logic [ADDR_W-1:0] a);
        strobe_t s;
        s.wr_ctrl   = wr && (a == OFS_CTRL);
        s.wr_cause  = wr && (a == OFS_CAUSE);
        s.wr_masked = wr && (a == OFS_MASKED);
        s.wr_set    = wr && (a == OFS_SET);
        s.wr_mask   = wr && (a == OFS_MASK);
        s.wr_mset   = wr && (a == OFS_MSET);
        s.wr_mclr   = wr && (a == OFS_MCLR);
        s.rd_cause  = rd && (a == OFS_CAUSE);
        s.rd_masked = rd && (a == OFS_MASKED);
        return s;
    endfunction

    function automatic logic is_write_only(logic [ADDR_W-1:0] a);
        return (a == OFS_SET) || (a == OFS_MSET) || (a == OFS_MCLR);
    endfunction

endpackage

// File: rtl/irq_cause_cell.sv
module irq_cause_cell (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic set_in,
    input  logic w1c_clr,
    input  logic cor_clr,
    input  logic mode_cor,
    output logic cause_d,
    output logic cause_q
);

    logic clr;

    always_comb begin
        clr     = mode_cor ? cor_clr : w1c_clr;
        cause_d = (cause_q & ~clr) | evt | set_in;
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= 1'b0;
        else     cause_q <= cause_d;
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        evt |=> cause_q); // R3

    AST_COR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode_cor && cor_clr && !evt && !set_in) |=> !cause_q); // R6

    AST_W1C_HOLDS_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (!mode_cor && !w1c_clr && cause_q) |=> cause_q); // R5

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_load,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [N_SRC-1:0] data,
    output logic [N_SRC-1:0] mask_d,
    output logic [N_SRC-1:0] mask_q
);

    always_comb begin
        mask_d = mask_q;
        if (wr_load)     mask_d = data;
        else if (wr_set) mask_d = mask_q | data;
        else if (wr_clr) mask_d = mask_q & ~data;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= mask_d;
    end

    AST_MSET_SETS: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((mask_q & $past(data)) == $past(data))); // R8

    AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((mask_q & $past(data)) == '0)); // R8

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_bank_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  ctrl_q,
    input  logic [N_SRC-1:0]  cause_q,
    input  logic [N_SRC-1:0]  mask_q,
    output logic [REG_W-1:0]  rd_data
);

    logic [N_SRC-1:0] sel;
    logic [REG_W-1:0] word;

    always_comb begin
        unique case (addr)
            OFS_CTRL:   sel = ctrl_q;
            OFS_CAUSE:  sel = cause_q;
            OFS_MASKED: sel = cause_q & ~mask_q;
            OFS_MASK:   sel = mask_q;
            default:    sel = '0;
        endcase
        word = '0;
        word[N_SRC-1:0] = sel;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= word;
    end

    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_write_only(addr)) |=> (rd_data == '0)); // R10

    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R2

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  hw_evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_out
);

    strobe_t          st;
    logic [N_SRC-1:0] wdat;
    logic [N_SRC-1:0] ctrl_q;
    logic [N_SRC-1:0] cause_d, cause_q;
    logic [N_SRC-1:0] mask_d, mask_q;

    assign st   = decode_strobes(wr_en, rd_en, reg_addr);
    assign wdat = wr_data[N_SRC-1:0];

    always_ff @(posedge clk) begin
        if (rst)             ctrl_q <= '0;
        else if (st.wr_ctrl) ctrl_q <= wdat;
    end

    irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_load (st.wr_mask),
        .wr_set  (st.wr_mset),
        .wr_clr  (st.wr_mclr),
        .data    (wdat),
        .mask_d  (mask_d),
        .mask_q  (mask_q)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic w1c_hit, cor_hit;
        assign w1c_hit = wdat[i] & (st.wr_cause | (st.wr_masked & ~mask_q[i]));
        assign cor_hit = st.rd_cause | (st.rd_masked & ~mask_q[i]);

        irq_cause_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .evt      (hw_evt[i]),
            .set_in   (st.wr_set & wdat[i]),
            .w1c_clr  (w1c_hit),
            .cor_clr  (cor_hit),
            .mode_cor (ctrl_q[i]),
            .cause_d  (cause_d[i]),
            .cause_q  (cause_q[i])
        );
    end

    irq_read_port #(.N_SRC(N_SRC)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (reg_addr),
        .ctrl_q  (ctrl_q),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |(cause_d & ~mask_d);
    end

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(cause_q & ~mask_q)); // R9

    AST_SET_SETS: assert property (@(posedge clk) disable iff (rst)
        st.wr_set |=> ((cause_q & $past(wdat)) == $past(wdat))); // R4

endmodule

// File: tb/tb_irq_cause_bank.sv
module tb_irq_cause_bank;
    import irq_bank_pkg::*;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  hw_evt;
    logic [2:0]    reg_addr;
    logic          wr_en, rd_en;
    logic [31:0]   wr_data;
    logic [31:0]   rd_data;
    logic          irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [N-1:0] m_ctrl, m_cause, m_mask;

    always #5 clk = ~clk;

    irq_cause_bank #(.N_SRC(N)) dut (
        .clk(clk), .rst(rst), .hw_evt(hw_evt), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(logic [N-1:0] x);
        return {{(32-N){1'b0}}, x};
    endfunction

    task automatic chk_irq(string tag);
        chk(tag, {31'b0, irq_out}, {31'b0, |(m_cause & ~m_mask)});
    endtask

    task automatic model_write(logic [2:0] a, logic [N-1:0] d);
        case (a)
            3'd0: m_ctrl  = d;
            3'd1: m_cause = m_cause & ~(d & ~m_ctrl);
            3'd2: m_cause = m_cause & ~(d & ~m_ctrl & ~m_mask);
            3'd3: m_cause = m_cause | d;
            3'd4: m_mask  = d;
            3'd5: m_mask  = m_mask | d;
            3'd6: m_mask  = m_mask & ~d;
            default: ;
        endcase
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d, logic [N-1:0] evt = '0);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1; hw_evt = evt;
        @(negedge clk);
        wr_en = 1'b0; hw_evt = '0;
        model_write(a, d[N-1:0]);
        m_cause = m_cause | evt;
    endtask

    task automatic rd(logic [2:0] a, string tag, logic [N-1:0] evt = '0);
        logic [31:0] exp;
        case (a)
            3'd0:    exp = ext(m_ctrl);
            3'd1:    exp = ext(m_cause);
            3'd2:    exp = ext(m_cause & ~m_mask);
            3'd4:    exp = ext(m_mask);
            default: exp = 32'h0;
        endcase
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1; hw_evt = evt;
        @(negedge clk);
        rd_en = 1'b0; hw_evt = '0;
        chk(tag, rd_data, exp);
        if (a == 3'd1) m_cause = m_cause & ~m_ctrl;
        if (a == 3'd2) m_cause = m_cause & ~(m_ctrl & ~m_mask);
        m_cause = m_cause | evt;
    endtask

    task automatic rd_all(string tag);
        rd(3'd0, {tag, " ctrl"});
        rd(3'd4, {tag, " mask"});
        rd(3'd2, {tag, " masked"});
        rd(3'd1, {tag, " cause"});
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; hw_evt = '0; reg_addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        m_ctrl = '0; m_cause = '0; m_mask = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data after reset", rd_data, 32'h0);
        chk_irq("R1 irq after reset");
        rd_all("R1 reset");
        rd(3'd3, "R10 set reads zero after reset");
        rd(3'd7, "R2 unused offset reads zero");

        // R2 unused offset ignores writes
        wr(3'd7, 32'hFFFF_FFFF);
        rd_all("R2 after offset-7 write");

        // R2 upper bits read as zero
        wr(3'd0, 32'hFFFF_FF00);
        rd(3'd0, "R2 upper ctrl bits zero");

        // Sweep every control pattern with a derived mask
        for (int v = 0; v < 256; v++) begin
            logic [N-1:0] vb;
            vb = v[N-1:0];
            wr(3'd0, ext(vb));
            rd(3'd0, "R2 ctrl readback");
            wr(3'd3, 32'hFF);
            rd(3'd3, "R10 set reads zero");
            wr(3'd4, ext(vb ^ 8'h3C));
            chk_irq("R9 irq after mask load");
            rd(3'd4, "R8 mask direct load");
            rd(3'd2, "R7 R6 masked read");
            chk_irq("R9 irq after masked read");
            wr(3'd1, 32'hFF);
            chk_irq("R9 irq after cause write");
            rd(3'd1, "R5 R6 cause after w1c write");
            rd(3'd1, "R6 cause after cor read");
            wr(3'd3, ext(vb ^ 8'h5A));
            rd(3'd1, "R4 cause after set write");
            wr(3'd5, ext(vb));
            rd(3'd5, "R10 mset reads zero");
            rd(3'd4, "R8 mask after mset");
            wr(3'd2, 32'hFF);
            rd(3'd2, "R5 masked after w1c via masked");
            wr(3'd6, 32'hFF);
            rd(3'd6, "R10 mclr reads zero");
            rd(3'd4, "R8 mask after mclr");
            chk_irq("R9 irq with all unmasked");
            wr(3'd1, 32'h0, vb);
            rd(3'd1, "R3 cause after hw event");
            // clear everything for the next pattern
            wr(3'd0, 32'hFF);
            rd(3'd1, "R6 cor flush");
            wr(3'd4, 32'hFF);
        end

        // R3 event collides with write-1-to-clear
        wr(3'd0, 32'h00);
        wr(3'd3, 32'hF0);
        wr(3'd1, 32'hF0, 8'h30);
        rd(3'd1, "R3 event beats w1c clear");
        // R3 event collides with clear-on-read
        wr(3'd0, 32'hFF);
        rd(3'd1, "R3 cor read with colliding event", 8'h10);
        rd(3'd1, "R3 bit kept after colliding read");
        // R6 writes do not clear cor bits
        wr(3'd3, 32'h81);
        wr(3'd1, 32'hFF);
        rd(3'd1, "R6 write ignored in cor mode");
        // R5 reads do not clear w1c bits
        wr(3'd0, 32'h00);
        wr(3'd3, 32'h42);
        rd(3'd1, "R5 read does not clear");
        rd(3'd1, "R5 read does not clear again");
        wr(3'd6, 32'h02);
        chk_irq("R9 irq rises with unmask");
        wr(3'd1, 32'h42);
        chk_irq("R9 irq falls after clear");
        rd_all("R1 final");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule